// File: doc/BRIEF.md
# Four-Bit Cascadable Arithmetic/Logic Slice

This block is a purely combinational four-bit arithmetic/logic slice. It takes two operand words and a four-bit function code. A mode input then decides how the code is read. With the mode input low, the slice adds two operand-derived terms plus a ripple carry. This covers sixteen operations, among them addition, subtraction with a ones-complement subtrahend, decrement and plain transfer. With the mode input high, internal carries play no part in the result and the slice returns one of the sixteen Boolean functions of two variables.

Wider words are built from several slices. The ripple carry chains them directly. Alternatively, the active-low group propagate and group generate outputs can feed an external lookahead unit. An equality flag is set when every result bit is one. In subtract mode with no carry, that condition means the operands are equal, and the carry output then tells the relative magnitude. Data is active high. Both carry pins are active low. A parameter picks between closed-form lookahead carries and a ripple chain inside the slice.

Top module: `cascade_alu`

## Requirements
- R1: With logic_mode=1, result per fsel is: 0000 ~A, 0001 ~(A|B), 0010 ~A&B, 0011 all zeros, 0100 ~(A&B), 0101 ~B, 0110 A^B, 0111 A&~B, 1000 ~A|B, 1001 ~(A^B), 1010 B, 1011 A&B, 1100 all ones, 1101 A|~B, 1110 A|B, 1111 A.
- R2: With logic_mode=0, result is the low four bits of X+Y+c, with c=1 when carry_in_n=0 and c=0 otherwise, and (X,Y) per fsel: 0000 (A,0), 0001 (A|B,0), 0010 (A|~B,0), 0011 (15,0), 0100 (A,A&~B), 0101 (A|B,A&~B), 0110 (A,~B), 0111 (A&~B,15), 1000 (A,A&B), 1001 (A,B), 1010 (A|~B,A&B), 1011 (A&B,15), 1100 (A,A), 1101 (A|B,A), 1110 (A|~B,A), 1111 (A,15).
- R3: carry_out_n is low exactly when X+Y+c of R2 exceeds 15. carry_in_n=0 adds one.
- R4: fsel=0110 with logic_mode=0 gives A-B-1 mod 16 when carry_in_n=1 and A-B mod 16 when carry_in_n=0.
- R5: equal is high exactly when all four result bits are one. In subtract mode (fsel=0110, logic_mode=0, carry_in_n=1) this happens exactly when A equals B.
- R6: In subtract mode with carry_in_n=1, carry_out_n is low exactly when A>B. With carry_in_n=0 it is low exactly when A>=B.
- R7: grp_prop_n is low exactly when every bit propagates, where bit i propagates if A[i] | (fsel[0]&B[i]) | (fsel[1]&~B[i]).
- R8: grp_gen_n is low exactly when the slice carries out with no carry in. That is the case exactly when the per-bit propagate vector plus the per-bit generate vector, with generate A[i]&B[i]&fsel[3] | A[i]&~B[i]&fsel[2], exceeds 15.
- R9: carry_out_n, grp_prop_n and grp_gen_n do not depend on logic_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 4 | Operand A |
| opb | input | 4 | Operand B |
| fsel | input | 4 | Function code |
| logic_mode | input | 1 | 1 = Boolean functions, 0 = arithmetic |
| carry_in_n | input | 1 | Ripple carry in, active low |
| result | output | 4 | Function output |
| carry_out_n | output | 1 | Ripple carry out, active low |
| grp_prop_n | output | 1 | Group propagate, active low |
| grp_gen_n | output | 1 | Group generate, active low |
| equal | output | 1 | High when all result bits are one |

## Verification
The slice holds no state. A wrong internal term therefore appears at the ports in the same cycle as the input pattern that exercises it. A broken bit-term selector shows up as a wrong result under specific function codes. It also shows as a wrong group propagate or group generate flag, and these flags are visible even in logic mode. A fault in the carry network shows up only for operand pairs whose carries cross bit boundaries, so the bench applies every combination of operands, function code, mode and carry-in. That sweep covers every carry path through the slice.

// File: rtl/alu_pkg.sv
package alu_pkg;
   localparam int unsigned SEL_W = 4;
   typedef logic [SEL_W-1:0] fsel_t;
   localparam fsel_t FSEL_SUB = 4'b0110;
   localparam fsel_t FSEL_ADD = 4'b1001;
   localparam fsel_t FSEL_XOR = 4'b0110;
   typedef enum logic { CARRY_RIPPLE = 1'b0, CARRY_LOOKAHEAD = 1'b1 } carry_style_e;
endpackage

// File: rtl/alu_term_gen.sv
module alu_term_gen
   import alu_pkg::*;
#(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  fsel_t        sel,
   output logic [W-1:0] prop,
   output logic [W-1:0] gen
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic b_pos, b_neg;
      assign b_pos   = sel[0] & b[i];
      assign b_neg   = sel[1] & ~b[i];
      assign prop[i] = a[i] | b_pos | b_neg;
      assign gen[i]  = a[i] & ((sel[3] & b[i]) | (sel[2] & ~b[i]));
   end
endmodule

// File: rtl/alu_carry_net.sv
module alu_carry_net
   import alu_pkg::*;
#(
   parameter int unsigned  W     = 4,
   parameter carry_style_e STYLE = CARRY_LOOKAHEAD
) (
   input  logic [W-1:0] prop,
   input  logic [W-1:0] gen,
   input  logic         cin,
   output logic [W:0]   carry,
   output logic         grp_prop,
   output logic         grp_gen
);
   assign grp_prop = &prop;

   if (STYLE == CARRY_LOOKAHEAD) begin : g_cla
      always_comb begin
         carry[0] = cin;
         for (int i = 0; i < W; i++) begin
            logic acc;
            logic chain;
            acc   = 1'b0;
            chain = 1'b1;
            for (int j = i; j >= 0; j--) begin
               acc   = acc | (chain & gen[j]);
               chain = chain & prop[j];
            end
            carry[i+1] = acc | (chain & cin);
         end
      end
      always_comb begin
         logic acc_g;
         logic chain_g;
         acc_g   = 1'b0;
         chain_g = 1'b1;
         for (int j = W - 1; j >= 0; j--) begin
            acc_g   = acc_g | (chain_g & gen[j]);
            chain_g = chain_g & prop[j];
         end
         grp_gen = acc_g;
      end
   end else begin : g_ripple
      logic [W:0] nocarry;
      assign carry[0]   = cin;
      assign nocarry[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_stage
         assign carry[i+1]   = gen[i] | (prop[i] & carry[i]);
         assign nocarry[i+1] = gen[i] | (prop[i] & nocarry[i]);
      end
      assign grp_gen = nocarry[W];
   end
endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] prop,
   input  logic [W-1:0] gen,
   input  logic [W-1:0] carry,
   input  logic         logic_sel,
   output logic [W-1:0] res,
   output logic         all_ones
);
   logic [W-1:0] half;
   assign half     = prop & ~gen;
   assign res      = logic_sel ? ~half : (half ^ carry);
   assign all_ones = &res;
endmodule

// File: rtl/cascade_alu.sv
module cascade_alu
   import alu_pkg::*;
#(
   parameter int unsigned  SLICE_W = 4,
   parameter carry_style_e STYLE   = CARRY_LOOKAHEAD
) (
   input  logic [SLICE_W-1:0] opa,
   input  logic [SLICE_W-1:0] opb,
   input  logic [3:0]         fsel,
   input  logic               logic_mode,
   input  logic               carry_in_n,
   output logic [SLICE_W-1:0] result,
   output logic               carry_out_n,
   output logic               grp_prop_n,
   output logic               grp_gen_n,
   output logic               equal
);
   localparam int unsigned MAX_W = 16;

   if (SLICE_W < 1 || SLICE_W > MAX_W) begin : g_bad_width
      $error("cascade_alu: SLICE_W out of range");
   end

   logic [SLICE_W-1:0] prop, gen;
   logic [SLICE_W:0]   carry;
   logic               gp, gg;

   alu_term_gen #(.W(SLICE_W)) u_terms (
      .a(opa), .b(opb), .sel(fsel), .prop(prop), .gen(gen)
   );

   alu_carry_net #(.W(SLICE_W), .STYLE(STYLE)) u_carry (
      .prop(prop), .gen(gen), .cin(~carry_in_n),
      .carry(carry), .grp_prop(gp), .grp_gen(gg)
   );

   alu_result_mux #(.W(SLICE_W)) u_out (
      .prop(prop), .gen(gen), .carry(carry[SLICE_W-1:0]),
      .logic_sel(logic_mode), .res(result), .all_ones(equal)
   );

   assign carry_out_n = ~carry[SLICE_W];
   assign grp_prop_n  = ~gp;
   assign grp_gen_n   = ~gg;
endmodule

// File: rtl/cascade_alu_chk.sv
module cascade_alu_chk
   import alu_pkg::*;
#(
   parameter int unsigned SLICE_W = 4
) (
   input logic [SLICE_W-1:0] opa,
   input logic [SLICE_W-1:0] opb,
   input logic [3:0]         fsel,
   input logic               logic_mode,
   input logic               carry_in_n,
   input logic [SLICE_W-1:0] result,
   input logic               carry_out_n,
   input logic               grp_prop_n,
   input logic               grp_gen_n,
   input logic               equal
);
   logic [SLICE_W:0] add_sum;
   assign add_sum = {1'b0, opa} + {1'b0, opb} + {{SLICE_W{1'b0}}, ~carry_in_n};

   always_comb begin
      if (!logic_mode && fsel == FSEL_ADD)
         assert_add_R2: assert ({~carry_out_n, result} == add_sum)
            else $error("add mismatch");
      if (logic_mode && fsel == FSEL_XOR)
         assert_xor_R1: assert (result == (opa ^ opb))
            else $error("xor mismatch");
      assert_equal_R5: assert (equal == (&result))
         else $error("equal flag mismatch");
      if (!logic_mode && fsel == FSEL_SUB && carry_in_n)
         assert_magnitude_R6: assert ((!carry_out_n) == (opa > opb))
            else $error("magnitude mismatch");
      if (!grp_gen_n)
         assert_gen_forces_carry_R8: assert (!carry_out_n)
            else $error("generate without carry out");
      if (!grp_prop_n && grp_gen_n)
         assert_prop_passes_carry_R7: assert (carry_out_n == carry_in_n)
            else $error("propagate does not pass carry");
   end
endmodule

bind cascade_alu cascade_alu_chk #(.SLICE_W(SLICE_W)) u_chk (
   .opa(opa), .opb(opb), .fsel(fsel), .logic_mode(logic_mode),
   .carry_in_n(carry_in_n), .result(result), .carry_out_n(carry_out_n),
   .grp_prop_n(grp_prop_n), .grp_gen_n(grp_gen_n), .equal(equal)
);

// File: tb/test_cascade_alu.sv
module test_cascade_alu;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] opa, opb, fsel, result;
   logic       logic_mode, carry_in_n, carry_out_n, grp_prop_n, grp_gen_n, equal;
   int         total = 0;
   int         bad = 0;
   int         cycles = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   cascade_alu i_cascade_alu (
      .opa(opa), .opb(opb), .fsel(fsel), .logic_mode(logic_mode),
      .carry_in_n(carry_in_n), .result(result), .carry_out_n(carry_out_n),
      .grp_prop_n(grp_prop_n), .grp_gen_n(grp_gen_n), .equal(equal)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: a=%0d b=%0d s=%0d m=%0d cn=%0d actual=%0d expected=%0d",
                  req, opa, opb, fsel, logic_mode, carry_in_n, act, exp);
      end
   endtask

   // behavioural model from the requirement tables
   function automatic int logic_fn(int s, int a, int b);
      int na = 15 - a, nb = 15 - b;
      case (s)
         0: return na;            1: return 15 - (a | b);
         2: return na & b;        3: return 0;
         4: return 15 - (a & b);  5: return nb;
         6: return a ^ b;         7: return a & nb;
         8: return na | b;        9: return 15 - (a ^ b);
         10: return b;            11: return a & b;
         12: return 15;           13: return a | nb;
         14: return a | b;        default: return a;
      endcase
   endfunction

   function automatic int arith_sum(int s, int a, int b, int c);
      int nb = 15 - b, x, y;
      case (s)
         0: begin x = a; y = 0; end
         1: begin x = a | b; y = 0; end
         2: begin x = a | nb; y = 0; end
         3: begin x = 15; y = 0; end
         4: begin x = a; y = a & nb; end
         5: begin x = a | b; y = a & nb; end
         6: begin x = a; y = nb; end
         7: begin x = a & nb; y = 15; end
         8: begin x = a; y = a & b; end
         9: begin x = a; y = b; end
         10: begin x = a | nb; y = a & b; end
         11: begin x = a & b; y = 15; end
         12: begin x = a; y = a; end
         13: begin x = a | b; y = a; end
         14: begin x = a | nb; y = a; end
         default: begin x = a; y = 15; end
      endcase
      return x + y + c;
   endfunction

   task automatic apply(input int a, input int b, input int s, input int m, input int cn);
      @(posedge clk);
      opa = 4'(a); opb = 4'(b); fsel = 4'(s); logic_mode = m[0]; carry_in_n = cn[0];
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      opa = 0; opb = 0; fsel = 0; logic_mode = 0; carry_in_n = 1;
      repeat (2) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // idle state: A=0, S=0000 arithmetic, no carry -> transfer of zero
      check("R2 idle", result, 0);
      check("R3 idle", carry_out_n, 1);
      check("R5 idle", equal, 0);

      // exhaustive sweep against the behavioural model
      for (int m = 0; m < 2; m++)
         for (int cn = 0; cn < 2; cn++)
            for (int s = 0; s < 16; s++)
               for (int a = 0; a < 16; a++)
                  for (int b = 0; b < 16; b++) begin
                     int sum, pv, gv, exp_res, exp_g;
                     apply(a, b, s, m, cn);
                     sum = arith_sum(s, a, b, 1 - cn);
                     pv = a | ((s & 1) ? b : 0) | ((s & 2) ? (15 - b) : 0);
                     gv = a & (((s & 8) ? b : 0) | ((s & 4) ? (15 - b) : 0));
                     exp_res = m ? logic_fn(s, a, b) : (sum & 15);
                     exp_g = (pv + gv) > 15 ? 1 : 0;
                     check(m ? "R1 result" : "R2 result", result, exp_res);
                     check(m ? "R9 carry" : "R3 carry", carry_out_n, sum > 15 ? 0 : 1);
                     check(m ? "R9 gprop" : "R7 gprop", grp_prop_n, pv == 15 ? 0 : 1);
                     check(m ? "R9 ggen" : "R8 ggen", grp_gen_n, exp_g ? 0 : 1);
                     check("R5 equal", equal, exp_res == 15 ? 1 : 0);
                  end

      // subtract corner cases
      apply(9, 4, 6, 0, 1); check("R4 a-b-1", result, 4);
      apply(9, 4, 6, 0, 0); check("R4 a-b", result, 5);
      apply(2, 7, 6, 0, 0); check("R4 wrap", result, 11);
      apply(7, 7, 6, 0, 1); check("R5 equal operands", equal, 1);
      apply(7, 6, 6, 0, 1); check("R5 unequal operands", equal, 0);
      apply(8, 3, 6, 0, 1); check("R6 a>b", carry_out_n, 0);
      apply(3, 3, 6, 0, 1); check("R6 a==b no carry", carry_out_n, 1);
      apply(3, 3, 6, 0, 0); check("R6 a==b forced carry", carry_out_n, 0);
      apply(2, 3, 6, 0, 0); check("R6 a<b", carry_out_n, 1);
      // add chaining boundary
      apply(15, 0, 9, 0, 0); check("R3 carry ripple", carry_out_n, 0);
      check("R3 wrap result", result, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule